// File: doc/BRIEF.md
# Taylor-Corrected Quadrature Sine/Cosine Synthesizer

This block generates a pair of quadrature samples, sine and cosine, from a running phase. A 32-bit phase register grows by a programmable tuning word on every clock with the enable high, so the output frequency is the tuning word times the clock rate divided by 2^32. The top phase bits pick an entry of a sine table. The table is read twice in the same cycle, once at the phase and once a quarter turn ahead, so one table gives both sine and cosine.

The phase bits below the table address form a residual angle that lies between two table points. The block does not interpolate linearly between neighbouring entries. It applies a first-order Taylor step instead: sine is moved by the residual angle times cosine, and cosine by the residual angle times minus sine, since each is the derivative of the other. A parameter adds the second-order term. A second parameter selects the table form: a full cycle, or a quarter cycle that is folded onto the whole wave by mirroring the address and negating the result. Results are clipped to a symmetric 16-bit range and come with a valid strobe after a fixed pipeline delay.

Top module: `qdds_taylor`

## Requirements
- R1: On each rising clock edge with `en` high, the phase advances by `ftw` modulo 2^32, using the `ftw` value present at that edge. With `en` low the phase holds. Reset clears the phase to 0.
- R2: Every valid sample lies within 2 LSB of 32767·sin(2πP/2^32) on `sin_out`, and within 2 LSB of 32767·cos(2πP/2^32) on `cos_out`. P is the phase the accumulator held just before the edge at which that sample was taken.
- R3: Outputs saturate at ±32767. The code -32768 never appears on `sin_out` or `cos_out`, including next to the peaks at phases 0x40000000, 0x80000000 and 0xC0000000.
- R4: When `en` is high at edge e, a sample is taken. It appears with `out_valid` high right after edge e+3, a latency of 4 cycles. `out_valid` is low in every cycle whose edge e-3 had `en` low.
- R5: While reset is held, `out_valid`, `sin_out` and `cos_out` are all 0. The first sample taken after reset has phase 0, so it reads exactly sine 0 and cosine 32767.
- R6: Phase bits 21:10 form the residual angle, in units of 2π/2^22. Samples with a nonzero residual still meet the R2 bound, because the sine slope is cosine and the cosine slope is minus sine.
- R7: Phases 0x40000000, 0x80000000 and 0xC0000000 give exactly (32767, 0), (0, -32767) and (-32767, 0) as (sine, cosine). Bits 31:30 select the quadrant: sine is never negative while bit 31 is 0, and never positive while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and take a sample at this edge |
| ftw | input | 32 | Frequency tuning word added to the phase |
| sin_out | output | 16 | Sine sample, two's complement |
| cos_out | output | 16 | Cosine sample, two's complement |
| out_valid | output | 1 | Samples on `sin_out`/`cos_out` are valid |

## Verification
The bench models the accumulator and computes the ideal sine and cosine for every sample, so a fault in the block shows up on the first valid sample it touches. A wrong quadrant fold or a wrong mirrored index breaks the sign or exactness checks at the quarter-turn phases, four cycles after that phase is sampled. A slope taken from the wrong output, or with the wrong sign, gives errors of up to about 200 LSB at large residuals. A phase accumulator that drops or repeats a step makes every later sample drift away from the model, so the error grows until it fails within a few samples.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

   localparam real TWO_PI = 6.283185307179586;

   // Rounded code of amplitude*sin(2*pi*k/2^addr_w), amplitude = 2^(out_w-1)-1
   function automatic int sine_code(input int k, input int addr_w, input int out_w);
      real amp;
      real v;
      amp = real'((1 << (out_w - 1)) - 1);
      v   = amp * $sin(TWO_PI * real'(k) / real'(1 << addr_w));
      if (v >= 0.0)
         return $rtoi(v + 0.5);
      return -$rtoi(0.5 - v);
   endfunction

endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic [PHASE_W-1:0] ftw,
   output logic [PHASE_W-1:0] phase
);

   always_ff @(posedge clk) begin
      if (rst)
         phase <= '0;
      else if (en)
         phase <= phase + ftw;
   end

   // R1: step by the word seen at the edge, hold otherwise
   p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
      en |=> phase == $past(phase) + $past(ftw));
   p_phase_hold_r1: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(phase));

endmodule

// File: rtl/qdds_sine_rom.sv
module qdds_sine_rom #(
   parameter int ADDR_W  = 10,
   parameter int OUT_W   = 16,
   parameter bit QUARTER = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ADDR_W-1:0]       addr_s,
   input  logic [ADDR_W-1:0]       addr_c,
   output logic signed [OUT_W-1:0] sin_v,
   output logic signed [OUT_W-1:0] cos_v
);

   localparam int FULL_D = 1 << ADDR_W;
   localparam int QTR_D  = (1 << (ADDR_W - 2)) + 1;
   localparam int QA_W   = ADDR_W - 1;

   if (ADDR_W < 3) begin : g_chk_addr
      $error("qdds_sine_rom: ADDR_W must be at least 3");
   end

   logic [ADDR_W-1:0]       rd_addr [2];
   logic signed [OUT_W-1:0] rd_val  [2];

   assign rd_addr[0] = addr_s;
   assign rd_addr[1] = addr_c;
   assign sin_v      = rd_val[0];
   assign cos_v      = rd_val[1];

   generate
      if (QUARTER) begin : g_quarter
         logic [OUT_W-1:0] qtab [QTR_D];
         initial begin
            for (int k = 0; k < QTR_D; k++)
               qtab[k] = OUT_W'(qdds_pkg::sine_code(k, ADDR_W, OUT_W));
         end
         for (genvar p = 0; p < 2; p++) begin : g_port
            logic [QA_W-1:0]         idx;
            logic [OUT_W-1:0]        mag_q;
            logic                    neg_q;
            logic signed [OUT_W-1:0] val_q;
            // second quadrant bit mirrors the index, top bit negates
            always_comb begin
               idx = {1'b0, rd_addr[p][ADDR_W-3:0]};
               if (rd_addr[p][ADDR_W-2])
                  idx = QA_W'(QTR_D - 1) - idx;
            end
            always_ff @(posedge clk) begin
               if (rst) begin
                  mag_q <= '0;
                  neg_q <= 1'b0;
                  val_q <= '0;
               end else begin
                  mag_q <= qtab[idx];
                  neg_q <= rd_addr[p][ADDR_W-1];
                  val_q <= neg_q ? -$signed(mag_q) : $signed(mag_q);
               end
            end
            assign rd_val[p] = val_q;
         end
      end else begin : g_full
         logic signed [OUT_W-1:0] ftab [FULL_D];
         initial begin
            for (int k = 0; k < FULL_D; k++)
               ftab[k] = OUT_W'(qdds_pkg::sine_code(k, ADDR_W, OUT_W));
         end
         for (genvar p = 0; p < 2; p++) begin : g_port
            logic signed [OUT_W-1:0] rd_q;
            logic signed [OUT_W-1:0] val_q;
            always_ff @(posedge clk) begin
               if (rst) begin
                  rd_q  <= '0;
                  val_q <= '0;
               end else begin
                  rd_q  <= ftab[rd_addr[p]];
                  val_q <= rd_q;
               end
            end
            assign rd_val[p] = val_q;
         end
      end
   endgenerate

   // R7: sine sign follows the phase half two reads back
   p_sin_upper_half_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(addr_s[ADDR_W-1], 2) |-> sin_v >= 0);
   p_sin_lower_half_r7: assert property (@(posedge clk) disable iff (rst)
      $past(addr_s[ADDR_W-1], 2) |-> sin_v <= 0);

endmodule

// File: rtl/qdds_taylor_fix.sv
module qdds_taylor_fix #(
   parameter int ADDR_W   = 10,
   parameter int RES_W    = 12,
   parameter int OUT_W    = 16,
   parameter int ANG_FRAC = 24,
   parameter int ORDER    = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [RES_W-1:0]        residual,
   input  logic signed [OUT_W-1:0] sin_v,
   input  logic signed [OUT_W-1:0] cos_v,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o
);

   localparam int     K_FRAC = ANG_FRAC / 2;
   localparam longint ANG_K  = longint'(qdds_pkg::TWO_PI * real'(longint'(1) << K_FRAC));
   localparam int     DK_W   = RES_W + K_FRAC + 3;
   localparam int     F0     = K_FRAC + ADDR_W + RES_W;
   localparam int     SH     = F0 - ANG_FRAC;
   localparam int     SH2    = 2 * F0 - ANG_FRAC + 1;
   localparam int     ANG_W  = ANG_FRAC - ADDR_W + 4;
   localparam int     PW     = OUT_W + ANG_W;
   localparam int     SW     = OUT_W + 2;
   localparam int     MAXV   = (1 << (OUT_W - 1)) - 1;
   localparam logic signed [PW-1:0]    HALF_LSB = PW'(64'd1 << (ANG_FRAC - 1));
   localparam logic signed [OUT_W-1:0] MINV     = OUT_W'(MAXV + 1);

   if (SH < 1) begin : g_chk_sh
      $error("qdds_taylor_fix: ANG_FRAC too large for the phase split");
   end
   if (ORDER != 1 && ORDER != 2) begin : g_chk_order
      $error("qdds_taylor_fix: ORDER must be 1 or 2");
   end

   // stage 2: residual scaled to radians with ANG_FRAC fraction bits
   logic [DK_W-1:0]         dk;
   logic [DK_W-1:0]         dk_rnd;
   logic signed [ANG_W-1:0] ang_q;
   logic signed [OUT_W-1:0] base_s, base_c;
   logic signed [PW-1:0]    lin_s, lin_c;
   logic signed [SW-1:0]    quad_s, quad_c;
   logic signed [SW-1:0]    sum_s, sum_c;

   assign dk     = DK_W'(residual) * DK_W'(ANG_K);
   assign dk_rnd = dk + (DK_W'(1) << (SH - 1));

   always_ff @(posedge clk) begin
      if (rst)
         ang_q <= '0;
      else
         ang_q <= $signed(ANG_W'(dk_rnd >> SH));
   end

   // stage 3: each output times the angle feeds the other
   always_ff @(posedge clk) begin
      if (rst) begin
         base_s <= '0;
         base_c <= '0;
         lin_s  <= '0;
         lin_c  <= '0;
      end else begin
         base_s <= sin_v;
         base_c <= cos_v;
         lin_s  <= PW'(cos_v) * PW'(ang_q);
         lin_c  <= PW'(sin_v) * PW'(ang_q);
      end
   end

   generate
      if (ORDER == 2) begin : g_second
         logic [2*DK_W-1:0]       sq;
         logic signed [ANG_W-1:0] hsq_q;
         logic signed [PW-1:0]    q_s, q_c;
         assign sq = (2*DK_W)'(dk) * (2*DK_W)'(dk) + ((2*DK_W)'(1) << (SH2 - 1));
         always_ff @(posedge clk) begin
            if (rst) begin
               hsq_q <= '0;
               q_s   <= '0;
               q_c   <= '0;
            end else begin
               hsq_q <= $signed(ANG_W'(sq >> SH2));
               q_s   <= PW'(sin_v) * PW'(hsq_q);
               q_c   <= PW'(cos_v) * PW'(hsq_q);
            end
         end
         assign quad_s = SW'((q_s + HALF_LSB) >>> ANG_FRAC);
         assign quad_c = SW'((q_c + HALF_LSB) >>> ANG_FRAC);
      end else begin : g_first
         assign quad_s = '0;
         assign quad_c = '0;
      end
   endgenerate

   // stage 4: round, add, clip
   function automatic logic signed [OUT_W-1:0] clip(input logic signed [SW-1:0] v);
      if (v > SW'(MAXV))
         return OUT_W'(MAXV);
      if (v < -SW'(MAXV))
         return -OUT_W'(MAXV);
      return v[OUT_W-1:0];
   endfunction

   assign sum_s = SW'(base_s) + SW'((lin_s + HALF_LSB) >>> ANG_FRAC) - quad_s;
   assign sum_c = SW'(base_c) - SW'((lin_c + HALF_LSB) >>> ANG_FRAC) - quad_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         sin_o <= '0;
         cos_o <= '0;
      end else begin
         sin_o <= clip(sum_s);
         cos_o <= clip(sum_c);
      end
   end

   // R3: the asymmetric negative code never leaves the block
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      sin_o != MINV && cos_o != MINV);

endmodule

// File: rtl/qdds_taylor.sv
module qdds_taylor #(
   parameter int PHASE_W      = 32,
   parameter int ADDR_W       = 10,
   parameter int RES_W        = 12,
   parameter int OUT_W        = 16,
   parameter int ANG_FRAC     = 24,
   parameter int TAYLOR_ORDER = 1,
   parameter bit QUARTER_TBL  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [PHASE_W-1:0]      ftw,
   output logic signed [OUT_W-1:0] sin_out,
   output logic signed [OUT_W-1:0] cos_out,
   output logic                    out_valid
);

   localparam int LATENCY = 4;
   localparam int LSB_W   = PHASE_W - ADDR_W - RES_W;
   localparam int WARM_W  = $clog2(LATENCY + 1);

   if (LSB_W < 0) begin : g_chk_split
      $error("qdds_taylor: ADDR_W + RES_W exceeds PHASE_W");
   end

   logic [PHASE_W-1:0] phase;
   logic [ADDR_W-1:0]  addr_s, addr_c;
   logic [RES_W-1:0]   res_q;
   logic [LATENCY-1:0] vld_sr;

   qdds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .ftw   (ftw),
      .phase (phase)
   );

   assign addr_s = phase[PHASE_W-1 -: ADDR_W];
   assign addr_c = addr_s + ADDR_W'(1 << (ADDR_W - 2));

   if (LSB_W > 0) begin : g_lsb
      logic unused_lsb;
      assign unused_lsb = ^phase[LSB_W-1:0];
   end

   // stage 1 for the residual, aligned with the table read
   always_ff @(posedge clk) begin
      if (rst)
         res_q <= '0;
      else
         res_q <= phase[PHASE_W-ADDR_W-1 -: RES_W];
   end

   logic signed [OUT_W-1:0] tab_s, tab_c;

   qdds_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W), .QUARTER(QUARTER_TBL)) u_rom (
      .clk    (clk),
      .rst    (rst),
      .addr_s (addr_s),
      .addr_c (addr_c),
      .sin_v  (tab_s),
      .cos_v  (tab_c)
   );

   qdds_taylor_fix #(
      .ADDR_W   (ADDR_W),
      .RES_W    (RES_W),
      .OUT_W    (OUT_W),
      .ANG_FRAC (ANG_FRAC),
      .ORDER    (TAYLOR_ORDER)
   ) u_fix (
      .clk      (clk),
      .rst      (rst),
      .residual (res_q),
      .sin_v    (tab_s),
      .cos_v    (tab_c),
      .sin_o    (sin_out),
      .cos_o    (cos_out)
   );

   always_ff @(posedge clk) begin
      if (rst)
         vld_sr <= '0;
      else
         vld_sr <= {vld_sr[LATENCY-2:0], en};
   end
   assign out_valid = vld_sr[LATENCY-1];

   // edges since reset, saturating at the latency, for the checker below
   logic [WARM_W-1:0] warm;
   always_ff @(posedge clk) begin
      if (rst)
         warm <= '0;
      else if (warm != WARM_W'(LATENCY))
         warm <= warm + 1'b1;
   end

   // R4: strobe follows the enable exactly LATENCY edges later
   p_valid_latency_r4: assert property (@(posedge clk) disable iff (rst)
      (warm == WARM_W'(LATENCY)) |-> out_valid == $past(en, 4));

endmodule

// File: tb/qdds_taylor_test.sv
`timescale 1ns/1ps
module qdds_taylor_test;

   localparam real PERIOD = 4.0;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en  = 1'b0;
   logic [31:0]        ftw = '0;
   logic signed [15:0] sin_out, cos_out;
   logic               out_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(PERIOD / 2.0) clk = ~clk;

   qdds_taylor uut (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .ftw       (ftw),
      .sin_out   (sin_out),
      .cos_out   (cos_out),
      .out_valid (out_valid)
   );

   // bench model of the accumulator and of the samples in flight
   logic [31:0] acc_m = '0;
   logic        h_en  [8];
   logic [31:0] h_ph  [8];
   string       h_tag [8];
   int          n = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic real ideal(input logic [31:0] ph, input bit want_cos);
      real a;
      a = 2.0 * 3.141592653589793 * real'(ph) / 4294967296.0;
      return 32767.0 * (want_cos ? $cos(a) : $sin(a));
   endfunction

   task automatic judge_value(input string tag, input string what,
                              input int act, input real exp);
      real d;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      check(d <= 2.0, tag, what, act, $rtoi(exp >= 0.0 ? exp + 0.5 : exp - 0.5));
   endtask

   task automatic judge();
      int          k;
      bit          exp_v;
      logic [31:0] ph;
      int          es, ec;
      k = n - 4;
      exp_v = (k >= 0) ? h_en[k & 7] : 1'b0;
      // R4: strobe timing
      check(out_valid == exp_v, (k >= 0) ? h_tag[k & 7] : "R4", "R4 valid",
            int'(out_valid), int'(exp_v));
      if (exp_v) begin
         ph = h_ph[k & 7];
         // R3: no asymmetric code
         check(sin_out != -16'sd32768, "R3", "sin range", int'(sin_out), -32767);
         check(cos_out != -16'sd32768, "R3", "cos range", int'(cos_out), -32767);
         if (ph[29:0] == 30'd0) begin
            // R7 (and R5 for phase 0): exact quadrant values
            case (ph[31:30])
               2'd0: begin es = 0;      ec = 32767;  end
               2'd1: begin es = 32767;  ec = 0;      end
               2'd2: begin es = 0;      ec = -32767; end
               default: begin es = -32767; ec = 0;   end
            endcase
            check(int'(sin_out) == es, h_tag[k & 7], "exact sin", int'(sin_out), es);
            check(int'(cos_out) == ec, h_tag[k & 7], "exact cos", int'(cos_out), ec);
         end else begin
            // R2 / R6: accuracy against the ideal waveform
            judge_value(h_tag[k & 7], "sin", int'(sin_out), ideal(ph, 1'b0));
            judge_value(h_tag[k & 7], "cos", int'(cos_out), ideal(ph, 1'b1));
         end
      end
   endtask

   task automatic step(input logic e, input logic [31:0] f, input string tag);
      en = e;
      ftw = f;
      h_en[n & 7]  = e;
      h_ph[n & 7]  = acc_m;
      h_tag[n & 7] = tag;
      if (e) acc_m = acc_m + f;
      n++;
      @(negedge clk);
      judge();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(PERIOD * 100000.0);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n, 0);
      finish_run();
   end

   initial begin
      logic        e;
      logic [31:0] cur;
      void'($urandom(32'd7321));
      for (int i = 0; i < 8; i++) begin
         h_en[i] = 1'b0;
         h_ph[i] = '0;
         h_tag[i] = "R4";
      end

      // R5: state while reset is held
      repeat (5) @(negedge clk);
      check(out_valid == 1'b0, "R5", "valid in reset", int'(out_valid), 0);
      check(sin_out == 16'sd0, "R5", "sin in reset", int'(sin_out), 0);
      check(cos_out == 16'sd0, "R5", "cos in reset", int'(cos_out), 0);
      rst = 1'b0;

      // R5 first sample at phase 0, then R7 quarter turns
      step(1'b1, 32'h4000_0000, "R5");
      for (int i = 0; i < 4; i++) step(1'b1, 32'h4000_0000, "R7");

      // R1/R4: hold phase with enable low, then resume
      for (int i = 0; i < 6; i++) step(1'b0, 32'h1234_5678, "R1");
      step(1'b1, 32'h0001_0000, "R1");
      for (int i = 0; i < 3; i++) step(1'b1, 32'h0001_0000, "R1");

      // R6: nonzero residual walk
      for (int i = 0; i < 300; i++) step(1'b1, 32'h0010_0A37, "R6");

      // R3: slow walks across the sine and cosine peaks
      step(1'b1, 32'h3FFF_F000 - acc_m, "R3");
      for (int i = 0; i < 48; i++) step(1'b1, 32'h0000_0100, "R3");
      step(1'b1, 32'hBFFF_F000 - acc_m, "R3");
      for (int i = 0; i < 48; i++) step(1'b1, 32'h0000_0100, "R3");
      step(1'b1, 32'h7FFF_F000 - acc_m, "R3");
      for (int i = 0; i < 48; i++) step(1'b1, 32'h0000_0100, "R3");

      // R2: random tuning words and enable pattern
      cur = 32'h0123_4567;
      for (int r = 0; r < 3000; r++) begin
         e = ($urandom % 5) != 0;
         if ($urandom % 50 == 0)
            cur = ($urandom % 4 == 0) ? ($urandom % 32'h0000_4000) : $urandom;
         step(e, cur, "R2");
      end

      for (int i = 0; i < 6; i++) step(1'b0, 32'h0, "R4");
      finish_run();
   end

endmodule